// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline and decides where each ALU operand comes from. For every operand it compares the source register named by the instruction in execute against the destinations of the two older instructions still in flight. It then picks one of four values: the copy read from the register file during decode, the ALU result in the execute/memory register, or the ALU result or loaded word in the memory/writeback register. Every bypass route runs from a later stage back to an earlier one.

A second, narrower path feeds the data memory's write-data input. A store now in the memory stage takes the word that the load immediately ahead of it has just brought in, so a load followed directly by a store of the same register needs no stall. The block is purely combinational: it produces mux selects together with the selected values. The ALU, the memory and the stall generation are outside it.

Top module: `operand_bypass`

## Requirements
- R1: Instruction class codes are 0 none, 1 register-register ALU, 2 register-immediate ALU, 3 load, 4 store, 5 branch. A stage writes a register only when its write enable is high and its class is 1, 2 or 3. The destination is rd for class 1 and rt for classes 2 and 3.
- R2: Operand A always uses rs. Operand B uses the immediate for classes 2, 3 and 4, and in that case it has select code 1 and equals the immediate, whatever matches exist. For any other class it uses rt.
- R3: If the execute/memory stage writes the operand's source register and is not a load, the select is 2 and the operand is the execute/memory ALU result.
- R4: Failing R3, if the memory/writeback stage writes the source register and is not a load, the select is 3 and the operand is the memory/writeback ALU result.
- R5: Failing R3, if the memory/writeback stage is a load that writes the source register, the select is 4 and the operand is the memory/writeback load data.
- R6: When both later stages write the same source register, the execute/memory result wins.
- R7: A match with an execute/memory load is ignored, and selection continues with the memory/writeback stage and then the register file.
- R8: A source register of 0 gives select 0 and the value zero. A destination of 0 never matches.
- R9: If the execute/memory stage holds a store (class 4) and the memory/writeback stage is an enabled load whose rt is nonzero and equals the store's rt, the store-data select is 1 and the store data is the load data. Otherwise the select is 0 and the store data is the execute/memory B value.
- R10: With no match, the select is 0 and the operand is the value read from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idx_cls | input | 3 | Class of the instruction in execute |
| idx_rs | input | REG_W | First source register |
| idx_rt | input | REG_W | Second source register |
| idx_a | input | DATA_W | Register-file value for rs |
| idx_b | input | DATA_W | Register-file value for rt |
| idx_imm | input | DATA_W | Sign-extended immediate |
| exm_wen | input | 1 | Execute/memory write enable |
| exm_cls | input | 3 | Execute/memory class |
| exm_rt | input | REG_W | Execute/memory rt field |
| exm_rd | input | REG_W | Execute/memory rd field |
| exm_alu | input | DATA_W | Execute/memory ALU result |
| exm_b | input | DATA_W | Execute/memory store data |
| mwb_wen | input | 1 | Memory/writeback write enable |
| mwb_cls | input | 3 | Memory/writeback class |
| mwb_rt | input | REG_W | Memory/writeback rt field |
| mwb_rd | input | REG_W | Memory/writeback rd field |
| mwb_alu | input | DATA_W | Memory/writeback ALU result |
| mwb_lmd | input | DATA_W | Memory/writeback load data |
| sel_a | output | 3 | Source select for operand A |
| sel_b | output | 3 | Source select for operand B |
| opnd_a | output | DATA_W | Operand A |
| opnd_b | output | DATA_W | Operand B |
| st_sel | output | 1 | Store-data select |
| st_data | output | DATA_W | Data-memory write data |

## Verification
Because the block holds no state, a wrong destination decode or a wrong priority shows up in the same cycle as a wrong select code next to a plausible but stale operand value. Stale operands are the dangerous case, since the value can look correct. For that reason the bench checks the select codes as well as the data, and it gives each stage data word a distinct value so that each source can be told apart. Narrow register indices make coincident matches in both stages, register 0 and load hazards frequent in the random traffic. Directed vectors then pin down each priority case.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam logic [2:0] CLS_NONE   = 3'd0;
  localparam logic [2:0] CLS_RR     = 3'd1;
  localparam logic [2:0] CLS_RI     = 3'd2;
  localparam logic [2:0] CLS_LOAD   = 3'd3;
  localparam logic [2:0] CLS_STORE  = 3'd4;
  localparam logic [2:0] CLS_BRANCH = 3'd5;

  localparam logic [2:0] SEL_RF     = 3'd0;
  localparam logic [2:0] SEL_IMM    = 3'd1;
  localparam logic [2:0] SEL_EXM    = 3'd2;
  localparam logic [2:0] SEL_WB_ALU = 3'd3;
  localparam logic [2:0] SEL_WB_LD  = 3'd4;

  function automatic logic cls_writes(input logic [2:0] cls);
    return (cls == CLS_RR) || (cls == CLS_RI) || (cls == CLS_LOAD);
  endfunction

  function automatic logic cls_imm_b(input logic [2:0] cls);
    return (cls == CLS_RI) || (cls == CLS_LOAD) || (cls == CLS_STORE);
  endfunction
endpackage

// File: rtl/bypass_dest.sv
module bypass_dest #(
  parameter int REG_W = 5
) (
  input  logic             wen,
  input  logic [2:0]       cls,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] dest,
  output logic             is_load
);
  import bypass_pkg::*;

  logic writes;

  always_comb begin
    writes  = wen && cls_writes(cls);
    is_load = writes && (cls == CLS_LOAD);
    if (!writes)          dest = '0;
    else if (cls == CLS_RR) dest = rd;
    else                  dest = rt;
  end

  always_comb begin
    if (wen && cls == CLS_RR)
      AST_RR_USES_RD: assert (dest == rd); // R1
    if (!wen)
      AST_NO_WEN_NO_DEST: assert (dest == '0 && !is_load); // R1
  end
endmodule

// File: rtl/bypass_operand_mux.sv
module bypass_operand_mux #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] imm,
  input  logic [REG_W-1:0]  exm_dest,
  input  logic              exm_is_load,
  input  logic [DATA_W-1:0] exm_alu,
  input  logic [REG_W-1:0]  mwb_dest,
  input  logic              mwb_is_load,
  input  logic [DATA_W-1:0] mwb_alu,
  input  logic [DATA_W-1:0] mwb_lmd,
  output logic [2:0]        sel,
  output logic [DATA_W-1:0] val
);
  import bypass_pkg::*;

  logic src_zero, exm_hit, mwb_hit;

  assign src_zero = (src == '0);
  assign exm_hit  = !src_zero && (exm_dest == src) && !exm_is_load;
  assign mwb_hit  = !src_zero && (mwb_dest == src);

  always_comb begin
    if (use_imm)      sel = SEL_IMM;
    else if (exm_hit) sel = SEL_EXM;
    else if (mwb_hit) sel = mwb_is_load ? SEL_WB_LD : SEL_WB_ALU;
    else              sel = SEL_RF;
  end

  always_comb begin
    case (sel)
      SEL_IMM:    val = imm;
      SEL_EXM:    val = exm_alu;
      SEL_WB_ALU: val = mwb_alu;
      SEL_WB_LD:  val = mwb_lmd;
      default:    val = src_zero ? '0 : rf_val;
    endcase
  end

  always_comb begin
    AST_SEL_LEGAL: assert (sel <= SEL_WB_LD); // R10
    if (use_imm)
      AST_IMM_KEPT: assert (sel == SEL_IMM && val == imm); // R2
    if (!use_imm && src_zero)
      AST_ZERO_SOURCE: assert (sel == SEL_RF && val == '0); // R8
    if (sel == SEL_EXM)
      AST_NO_EXM_LOAD_FWD: assert (!exm_is_load); // R7
    if (sel == SEL_WB_LD)
      AST_WB_LOAD_ONLY: assert (mwb_is_load && !exm_hit); // R5
  end
endmodule

// File: rtl/bypass_store_path.sv
module bypass_store_path #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [2:0]        exm_cls,
  input  logic [REG_W-1:0]  exm_rt,
  input  logic [DATA_W-1:0] exm_b,
  input  logic [REG_W-1:0]  mwb_dest,
  input  logic              mwb_is_load,
  input  logic [DATA_W-1:0] mwb_lmd,
  output logic              st_sel,
  output logic [DATA_W-1:0] st_data
);
  import bypass_pkg::*;

  logic ld_st_hit;

  assign ld_st_hit = (exm_cls == CLS_STORE) && mwb_is_load
                     && (exm_rt != '0) && (mwb_dest == exm_rt);
  assign st_sel  = ld_st_hit;
  assign st_data = ld_st_hit ? mwb_lmd : exm_b;

  always_comb begin
    if (exm_cls != CLS_STORE)
      AST_ST_ONLY_STORE: assert (!st_sel && st_data == exm_b); // R9
  end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [2:0]        idx_cls,
  input  logic [REG_W-1:0]  idx_rs,
  input  logic [REG_W-1:0]  idx_rt,
  input  logic [DATA_W-1:0] idx_a,
  input  logic [DATA_W-1:0] idx_b,
  input  logic [DATA_W-1:0] idx_imm,
  input  logic              exm_wen,
  input  logic [2:0]        exm_cls,
  input  logic [REG_W-1:0]  exm_rt,
  input  logic [REG_W-1:0]  exm_rd,
  input  logic [DATA_W-1:0] exm_alu,
  input  logic [DATA_W-1:0] exm_b,
  input  logic              mwb_wen,
  input  logic [2:0]        mwb_cls,
  input  logic [REG_W-1:0]  mwb_rt,
  input  logic [REG_W-1:0]  mwb_rd,
  input  logic [DATA_W-1:0] mwb_alu,
  input  logic [DATA_W-1:0] mwb_lmd,
  output logic [2:0]        sel_a,
  output logic [2:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              st_sel,
  output logic [DATA_W-1:0] st_data
);
  import bypass_pkg::*;

  localparam int NUM_OPND = 2;

  logic [REG_W-1:0] exm_dest, mwb_dest;
  logic             exm_is_load, mwb_is_load;

  logic [NUM_OPND-1:0][REG_W-1:0]  src_reg;
  logic [NUM_OPND-1:0]             src_imm;
  logic [NUM_OPND-1:0][DATA_W-1:0] src_rf;
  logic [NUM_OPND-1:0][2:0]        opnd_sel;
  logic [NUM_OPND-1:0][DATA_W-1:0] opnd_val;

  bypass_dest #(.REG_W(REG_W)) i_exm_dest (
    .wen(exm_wen), .cls(exm_cls), .rt(exm_rt), .rd(exm_rd),
    .dest(exm_dest), .is_load(exm_is_load)
  );

  bypass_dest #(.REG_W(REG_W)) i_mwb_dest (
    .wen(mwb_wen), .cls(mwb_cls), .rt(mwb_rt), .rd(mwb_rd),
    .dest(mwb_dest), .is_load(mwb_is_load)
  );

  assign src_reg[0] = idx_rs;
  assign src_imm[0] = 1'b0;
  assign src_rf[0]  = idx_a;
  assign src_reg[1] = idx_rt;
  assign src_imm[1] = cls_imm_b(idx_cls);
  assign src_rf[1]  = idx_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    bypass_operand_mux #(.REG_W(REG_W), .DATA_W(DATA_W)) i_mux (
      .src(src_reg[g]), .use_imm(src_imm[g]), .rf_val(src_rf[g]), .imm(idx_imm),
      .exm_dest(exm_dest), .exm_is_load(exm_is_load), .exm_alu(exm_alu),
      .mwb_dest(mwb_dest), .mwb_is_load(mwb_is_load), .mwb_alu(mwb_alu),
      .mwb_lmd(mwb_lmd), .sel(opnd_sel[g]), .val(opnd_val[g])
    );
  end

  bypass_store_path #(.REG_W(REG_W), .DATA_W(DATA_W)) i_store (
    .exm_cls(exm_cls), .exm_rt(exm_rt), .exm_b(exm_b),
    .mwb_dest(mwb_dest), .mwb_is_load(mwb_is_load), .mwb_lmd(mwb_lmd),
    .st_sel(st_sel), .st_data(st_data)
  );

  assign sel_a  = opnd_sel[0];
  assign sel_b  = opnd_sel[1];
  assign opnd_a = opnd_val[0];
  assign opnd_b = opnd_val[1];

  always_comb begin
    if (sel_a == SEL_WB_ALU || sel_a == SEL_WB_LD)
      AST_YOUNGER_FIRST: assert (exm_dest != idx_rs || exm_is_load); // R6
  end
endmodule

// File: tb/test_operand_bypass.sv
module test_operand_bypass;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] idx_cls, exm_cls, mwb_cls;
  logic [RW-1:0] idx_rs, idx_rt, exm_rt, exm_rd, mwb_rt, mwb_rd;
  logic [DW-1:0] idx_a, idx_b, idx_imm, exm_alu, exm_b, mwb_alu, mwb_lmd;
  logic exm_wen, mwb_wen;
  logic [2:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, st_data;
  logic st_sel;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  operand_bypass #(.REG_W(RW), .DATA_W(DW)) i_operand_bypass (.*);

  // destination written by a stage, or -1 if none (R1, R8)
  function automatic int dst_of(int wen, int cls, int rt, int rd);
    int d;
    if (wen == 0) return -1;
    case (cls)
      1: d = rd;
      2, 3: d = rt;
      default: d = -1;
    endcase
    return (d == 0) ? -1 : d;
  endfunction

  task automatic expect_opnd(input int src, input bit imm_op, input logic [DW-1:0] rf,
                             output int es, output logic [DW-1:0] ev);
    int ed, md;
    ed = dst_of(exm_wen, exm_cls, exm_rt, exm_rd);
    md = dst_of(mwb_wen, mwb_cls, mwb_rt, mwb_rd);
    if (imm_op) begin es = 1; ev = idx_imm; end
    else if (src == 0) begin es = 0; ev = '0; end
    else if (ed == src && exm_cls != 3) begin es = 2; ev = exm_alu; end
    else if (md == src) begin
      if (mwb_cls == 3) begin es = 4; ev = mwb_lmd; end
      else begin es = 3; ev = mwb_alu; end
    end else begin es = 0; ev = rf; end
  endtask

  task automatic check(input string req);
    int ea, eb, es;
    logic [DW-1:0] va, vb, vs;
    bit bimm;
    bimm = (idx_cls == 2 || idx_cls == 3 || idx_cls == 4);
    expect_opnd(idx_rs, 1'b0, idx_a, ea, va);
    expect_opnd(idx_rt, bimm, idx_b, eb, vb);
    if (exm_cls == 4 && mwb_wen && mwb_cls == 3 && exm_rt != 0 && mwb_rt == exm_rt) begin
      es = 1; vs = mwb_lmd;
    end else begin es = 0; vs = exm_b; end
    n_vec++;
    if (sel_a !== 3'(ea) || opnd_a !== va) begin
      n_bad++;
      $display("FAIL %s operand A: got sel %0d val %h, want sel %0d val %h", req, sel_a, opnd_a, ea, va);
    end
    if (sel_b !== 3'(eb) || opnd_b !== vb) begin
      n_bad++;
      $display("FAIL %s operand B: got sel %0d val %h, want sel %0d val %h", req, sel_b, opnd_b, eb, vb);
    end
    if (st_sel !== 1'(es) || st_data !== vs) begin
      n_bad++;
      $display("FAIL %s store data: got sel %0d val %h, want sel %0d val %h", req, st_sel, st_data, es, vs);
    end
  endtask

  task automatic base();
    idx_cls = 1; idx_rs = 5'd1; idx_rt = 5'd2;
    idx_a = 32'hA0A0_0001; idx_b = 32'hB0B0_0002; idx_imm = 32'h0000_1111;
    exm_wen = 0; exm_cls = 0; exm_rt = 0; exm_rd = 0;
    exm_alu = 32'hE1E1_0003; exm_b = 32'hE2E2_0004;
    mwb_wen = 0; mwb_cls = 0; mwb_rt = 0; mwb_rd = 0;
    mwb_alu = 32'hC1C1_0005; mwb_lmd = 32'hD1D1_0006;
  endtask

  task automatic step(input string req);
    #1;
    check(req);
    @(negedge clk);
  endtask

  initial begin
    idx_cls = 0; idx_rs = 0; idx_rt = 0; idx_a = 0; idx_b = 0; idx_imm = 0;
    exm_wen = 0; exm_cls = 0; exm_rt = 0; exm_rd = 0; exm_alu = 0; exm_b = 0;
    mwb_wen = 0; mwb_cls = 0; mwb_rt = 0; mwb_rd = 0; mwb_alu = 0; mwb_lmd = 0;
    @(negedge clk);
    step("R8 idle all-zero");
    if (sel_a !== 3'd0 || opnd_a !== '0) begin
      n_bad++; $display("FAIL R8 idle: sel %0d val %h, want 0 0", sel_a, opnd_a);
    end

    base(); step("R10 no match");
    base(); exm_wen = 1; exm_cls = 1; exm_rd = 1; exm_rt = 2; step("R1 R3 rr dest rd on A");
    base(); exm_wen = 1; exm_cls = 2; exm_rt = 2; exm_rd = 1; step("R1 R3 ri dest rt on B");
    base(); mwb_wen = 1; mwb_cls = 1; mwb_rd = 1; step("R4 wb alu to A");
    base(); mwb_wen = 1; mwb_cls = 3; mwb_rt = 2; step("R5 wb load to B");
    base(); exm_wen = 1; exm_cls = 1; exm_rd = 1; mwb_wen = 1; mwb_cls = 1; mwb_rd = 1; step("R6 younger wins");
    base(); exm_wen = 1; exm_cls = 3; exm_rt = 1; mwb_wen = 1; mwb_cls = 1; mwb_rd = 1; step("R7 exm load ignored");
    base(); exm_wen = 1; exm_cls = 3; exm_rt = 1; step("R7 exm load falls to regfile");
    base(); idx_cls = 2; exm_wen = 1; exm_cls = 1; exm_rd = 2; step("R2 imm not replaced");
    base(); idx_rs = 0; exm_wen = 1; exm_cls = 1; exm_rd = 0; step("R8 r0 source and dest");
    base(); exm_wen = 0; exm_cls = 1; exm_rd = 1; step("R1 no write without enable");
    base(); exm_cls = 4; exm_rt = 3; mwb_wen = 1; mwb_cls = 3; mwb_rt = 3; step("R9 load to store");
    base(); exm_cls = 4; exm_rt = 3; mwb_wen = 1; mwb_cls = 2; mwb_rt = 3; step("R9 non-load no bypass");
    base(); exm_cls = 4; exm_rt = 0; mwb_wen = 1; mwb_cls = 3; mwb_rt = 0; step("R9 r0 store");

    for (int k = 0; k < 3000; k++) begin
      idx_cls = 3'($urandom_range(0, 5)); exm_cls = 3'($urandom_range(0, 5));
      mwb_cls = 3'($urandom_range(0, 5));
      idx_rs = RW'($urandom_range(0, 3)); idx_rt = RW'($urandom_range(0, 3));
      exm_rt = RW'($urandom_range(0, 3)); exm_rd = RW'($urandom_range(0, 3));
      mwb_rt = RW'($urandom_range(0, 3)); mwb_rd = RW'($urandom_range(0, 3));
      exm_wen = 1'($urandom_range(0, 3) != 0); mwb_wen = 1'($urandom_range(0, 3) != 0);
      idx_a = $urandom; idx_b = $urandom; idx_imm = $urandom;
      exm_alu = $urandom; exm_b = $urandom; mwb_alu = $urandom; mwb_lmd = $urandom;
      step("random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got unfinished, want done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule